// File: doc/BRIEF.md
# Classification Program Sequencer

This block walks a small classification program held in an external synchronous instruction memory. A match front-end supplies a start address together with a 256-bit packet header. The sequencer latches both, then fetches one 64-bit instruction at a time. Each compare instruction selects a 16-bit field of the header and ANDs it with a mask. It then tests the result against a constant and branches to one of two addresses. A table instruction instead turns a few bits of the masked field into an offset from a base address. The program ends on a terminal instruction that delivers a 32-bit classification record. The meaning of the record is left to the blocks downstream.

Every instruction takes four clock cycles: fetch, decode, mask and compare. The memory read issued in the fetch cycle returns its word in the next cycle. A program that loops without reaching its terminal instruction is cut off by an instruction budget. In that case a default record is delivered and flagged as forced. Arbitration of the shared instruction memory is handled outside this block.

Top module: `classSeq`

## Requirements
- R1: When `startValid` is high while `busy` is low, `busy` rises in the next cycle and the first fetch reads `startAddr`. While `busy` is high, `startValid`, `startAddr` and `header` are ignored.
- R2: Every instruction takes exactly four cycles. `memRe` is high only in the first of them, for one cycle, with `memAddr` equal to that instruction's address. `memData` is sampled in the cycle after.
- R3: The instruction word is laid out as opcode[63:60], field select[59:56], mask[55:40], constant[39:24], false target[23:12] and true target[11:0]. Field n is header[16n+15:16n]. Compares are unsigned on (field AND mask) against the constant. The opcodes are 0 equal, 1 less, 2 less-or-equal, 3 greater and 4 greater-or-equal.
- R4: Opcodes 5 (less), 6 (less-or-equal), 7 (greater) and 8 (greater-or-equal) compare only bits [7:0] of the masked field with bits [7:0] of the constant.
- R5: After a compare, the next address is the true target if the test holds, and the false target otherwise.
- R6: Opcode 9 jumps to the true target plus bits [3:0] of the masked field. Opcode 10 jumps to the true target plus bits [7:0]. The sum wraps in 12 bits.
- R7: Opcode 11 ends the program. In the cycle after its compare phase, `recValid` is high for one cycle, `record` equals instruction bits [31:0], `recForced` is low and `busy` is low.
- R8: If 256 instructions execute without opcode 11, `recValid` pulses after the 256th with `record` = 0xBAD00BAD and `recForced` high.
- R9: After reset, `busy`, `memRe` and `recValid` are low.
- R10: Opcodes 12 to 15 are treated as a compare that fails, so execution continues at the false target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Start request from the match stage |
| startAddr | input | 12 | Program entry address |
| header | input | 256 | Packet header to classify |
| busy | output | 1 | A program is running |
| memRe | output | 1 | Instruction read strobe |
| memAddr | output | 12 | Instruction read address |
| memData | input | 64 | Instruction word, one cycle after the read |
| recValid | output | 1 | Record valid pulse |
| record | output | 32 | Classification record |
| recForced | output | 1 | Record came from the instruction budget |

## Verification
A wrong program counter shows up as a wrong `memAddr` on the very next fetch strobe, four cycles after the faulty instruction begins. A wrong compare or masking result has the same effect, as does a wrong table offset. A phase sequence that slips shows up as a `memRe` pulse or a `recValid` pulse one cycle off. A bad latched header or a bad instruction register changes the branch path, and so the fetch addresses and the final record. The reference model predicts every fetch address and the record cycle exactly, so such a fault appears within one instruction of its origin.

// File: rtl/classSeqPkg.sv
package classSeqPkg;
  localparam int ADDR_W  = 12;
  localparam int INSTR_W = 64;
  localparam int FIELD_W = 16;
  localparam int REC_W   = 32;

  localparam logic [3:0] OP_CMP  = 4'd0;
  localparam logic [3:0] OP_LTH  = 4'd1;
  localparam logic [3:0] OP_LTE  = 4'd2;
  localparam logic [3:0] OP_GTH  = 4'd3;
  localparam logic [3:0] OP_GTE  = 4'd4;
  localparam logic [3:0] OP_BLT  = 4'd5;
  localparam logic [3:0] OP_BLE  = 4'd6;
  localparam logic [3:0] OP_BGT  = 4'd7;
  localparam logic [3:0] OP_BGE  = 4'd8;
  localparam logic [3:0] OP_TAB4 = 4'd9;
  localparam logic [3:0] OP_TAB8 = 4'd10;
  localparam logic [3:0] OP_EXE  = 4'd11;

  typedef struct packed {
    logic [3:0]         op;
    logic [3:0]         regSel;
    logic [FIELD_W-1:0] mask;
    logic [FIELD_W-1:0] cmpConst;
    logic [ADDR_W-1:0]  falseAddr;
    logic [ADDR_W-1:0]  trueAddr;
  } instr_t;

  typedef struct packed {
    logic loadStart;
    logic loadInstr;
    logic loadMasked;
    logic commit;
    logic emitRecord;
    logic emitDefault;
  } strobes_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_FETCH, PH_DECODE, PH_MASK, PH_COMPARE
  } phase_e;
endpackage

// File: rtl/classSeqCtrl.sv
module classSeqCtrl
  import classSeqPkg::*;
#(
  parameter int WDOG_LIMIT = 256
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startValid,
  input  logic     isExe,
  output strobes_t stb,
  output logic     memRe,
  output logic     busy
);
  localparam int WD_W = $clog2(WDOG_LIMIT) + 1;
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WDOG_LIMIT - 1);

  phase_e phase, phaseNext;
  logic [WD_W-1:0] wdCount;
  logic budgetOut;

  assign budgetOut = (wdCount == WD_LAST);

  always_comb begin
    phaseNext = phase;
    stb = '0;
    unique case (phase)
      PH_IDLE: if (startValid) begin
        stb.loadStart = 1'b1;
        phaseNext = PH_FETCH;
      end
      PH_FETCH:  phaseNext = PH_DECODE;
      PH_DECODE: begin
        stb.loadInstr = 1'b1;
        phaseNext = PH_MASK;
      end
      PH_MASK: begin
        stb.loadMasked = 1'b1;
        phaseNext = PH_COMPARE;
      end
      PH_COMPARE: begin
        if (isExe) begin
          stb.emitRecord = 1'b1;
          phaseNext = PH_IDLE;
        end else if (budgetOut) begin
          stb.emitDefault = 1'b1;
          phaseNext = PH_IDLE;
        end else begin
          stb.commit = 1'b1;
          phaseNext = PH_FETCH;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      wdCount <= '0;
    end else begin
      phase <= phaseNext;
      if (stb.loadStart)   wdCount <= '0;
      else if (stb.commit) wdCount <= wdCount + 1'b1;
    end
  end

  assign memRe = (phase == PH_FETCH);
  assign busy  = (phase != PH_IDLE);
endmodule

// File: rtl/classSeqDatapath.sv
module classSeqDatapath
  import classSeqPkg::*;
#(
  parameter int HDR_W = 256,
  parameter logic [REC_W-1:0] DEFAULT_REC = 32'hBAD0_0BAD
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  input  logic [ADDR_W-1:0]  startAddr,
  input  logic [HDR_W-1:0]   header,
  input  logic [INSTR_W-1:0] memData,
  output logic [ADDR_W-1:0]  pcOut,
  output logic               isExe,
  output logic               recValid,
  output logic [REC_W-1:0]   record,
  output logic               recForced
);
  localparam int NUM_FIELDS = HDR_W / FIELD_W;
  localparam int SEL_W = $clog2(NUM_FIELDS);

  logic [HDR_W-1:0]   hdrReg;
  logic [ADDR_W-1:0]  pc, nextPc;
  instr_t             instrReg;
  logic [FIELD_W-1:0] maskedReg;
  logic [FIELD_W-1:0] fieldArr [NUM_FIELDS];
  logic               cond;

  generate
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : gField
      assign fieldArr[g] = hdrReg[g*FIELD_W +: FIELD_W];
    end
  endgenerate

  // Compare unit: full-width and low-byte unsigned tests.
  always_comb begin
    logic [7:0] lowA, lowB;
    lowA = maskedReg[7:0];
    lowB = instrReg.cmpConst[7:0];
    unique case (instrReg.op)
      OP_CMP:  cond = (maskedReg == instrReg.cmpConst);
      OP_LTH:  cond = (maskedReg <  instrReg.cmpConst);
      OP_LTE:  cond = (maskedReg <= instrReg.cmpConst);
      OP_GTH:  cond = (maskedReg >  instrReg.cmpConst);
      OP_GTE:  cond = (maskedReg >= instrReg.cmpConst);
      OP_BLT:  cond = (lowA <  lowB);
      OP_BLE:  cond = (lowA <= lowB);
      OP_BGT:  cond = (lowA >  lowB);
      OP_BGE:  cond = (lowA >= lowB);
      default: cond = 1'b0;
    endcase
  end

  // Next-address unit.
  always_comb begin
    unique case (instrReg.op)
      OP_TAB4: nextPc = instrReg.trueAddr + ADDR_W'(maskedReg[3:0]);
      OP_TAB8: nextPc = instrReg.trueAddr + ADDR_W'(maskedReg[7:0]);
      default: nextPc = cond ? instrReg.trueAddr : instrReg.falseAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrReg    <= '0;
      pc        <= '0;
      instrReg  <= '0;
      maskedReg <= '0;
      recValid  <= 1'b0;
      record    <= '0;
      recForced <= 1'b0;
    end else begin
      if (stb.loadStart) begin
        hdrReg <= header;
        pc     <= startAddr;
      end
      if (stb.loadInstr)  instrReg  <= instr_t'(memData);
      if (stb.loadMasked) maskedReg <= fieldArr[instrReg.regSel[SEL_W-1:0]] & instrReg.mask;
      if (stb.commit)     pc        <= nextPc;
      recValid <= stb.emitRecord | stb.emitDefault;
      if (stb.emitRecord) begin
        record    <= instrReg[REC_W-1:0];
        recForced <= 1'b0;
      end else if (stb.emitDefault) begin
        record    <= DEFAULT_REC;
        recForced <= 1'b1;
      end
    end
  end

  assign pcOut = pc;
  assign isExe = (instrReg.op == OP_EXE);
endmodule

// File: rtl/classSeq.sv
module classSeq
  import classSeqPkg::*;
#(
  parameter int HDR_W = 256,
  parameter int WDOG_LIMIT = 256,
  parameter logic [31:0] DEFAULT_REC = 32'hBAD0_0BAD
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startValid,
  input  logic [11:0]  startAddr,
  input  logic [HDR_W-1:0] header,
  output logic         busy,
  output logic         memRe,
  output logic [11:0]  memAddr,
  input  logic [63:0]  memData,
  output logic         recValid,
  output logic [31:0]  record,
  output logic         recForced
);
  strobes_t stb;
  logic isExe;

  classSeqCtrl #(.WDOG_LIMIT(WDOG_LIMIT)) ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .isExe(isExe),
    .stb(stb), .memRe(memRe), .busy(busy)
  );

  classSeqDatapath #(.HDR_W(HDR_W), .DEFAULT_REC(DEFAULT_REC)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .startAddr(startAddr), .header(header),
    .memData(memData), .pcOut(memAddr), .isExe(isExe), .recValid(recValid),
    .record(record), .recForced(recForced)
  );
endmodule

// File: rtl/classSeqChecker.sv
module classSeqChecker #(
  parameter int WDOG_LIMIT = 256
) (
  input logic clk,
  input logic rstN,
  input logic startValid,
  input logic busy,
  input logic memRe,
  input logic recValid,
  input logic recForced
);
  int busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  assert_start_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !busy) |=> busy);
  assert_fetch_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> !memRe);
  assert_fetch_in_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> busy);
  assert_rec_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    recValid |=> !recValid);
  assert_rec_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> !busy);
  assert_forced_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    recForced && recValid |-> $fell(busy));
  assert_budget_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= 4 * WDOG_LIMIT);
endmodule

bind classSeq classSeqChecker #(.WDOG_LIMIT(WDOG_LIMIT)) chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .busy(busy),
  .memRe(memRe), .recValid(recValid), .recForced(recForced)
);

// File: tb/classSeq_test.sv
module classSeq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DEF_REC = 32'hBAD0_0BAD;

  logic clk = 0, rstN = 0, startValid = 0;
  logic [11:0] startAddr = '0;
  logic [255:0] header = '0;
  logic busy, memRe, recValid, recForced;
  logic [11:0] memAddr;
  logic [63:0] memData = '0;
  logic [31:0] record;

  int compared = 0, mismatched = 0, cycles = 0;
  logic [63:0] mem [int];
  int pcQ[$];

  classSeq uut (.clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .header(header), .busy(busy), .memRe(memRe), .memAddr(memAddr), .memData(memData),
    .recValid(recValid), .record(record), .recForced(recForced));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    memData <= (memRe && mem.exists(int'(memAddr))) ? mem[int'(memAddr)] : 64'd0;
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic logic [63:0] mk(int op, int rs, int mask, int cst, int fa, int ta);
    return {4'(op), 4'(rs), 16'(mask), 16'(cst), 12'(fa), 12'(ta)};
  endfunction
  function automatic logic [63:0] exe(logic [31:0] rec);
    return {4'd11, 28'd0, rec};
  endfunction
  function automatic logic [255:0] hdrWith(int rs, int val);
    logic [255:0] h = {16{16'hA5C3}};
    h[rs*16 +: 16] = 16'(val);
    return h;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: walks the program, records fetch addresses.
  task automatic refRun(input int sa, input logic [255:0] h,
                        output logic [31:0] rec, output bit forced);
    int pc = sa;
    pcQ.delete();
    rec = DEF_REC; forced = 1;
    for (int i = 0; i < 256; i++) begin
      logic [63:0] w;
      int op, v, c, ta, fa;
      bit t;
      pcQ.push_back(pc);
      w  = mem.exists(pc) ? mem[pc] : 64'd0;
      op = int'(w[63:60]);
      v  = int'(h[int'(w[59:56])*16 +: 16]) & int'(w[55:40]);
      c  = int'(w[39:24]);
      fa = int'(w[23:12]); ta = int'(w[11:0]);
      if (op == 11) begin rec = w[31:0]; forced = 0; return; end
      case (op)
        0: t = v == c;
        1: t = v < c;
        2: t = v <= c;
        3: t = v > c;
        4: t = v >= c;
        5: t = (v % 256) < (c % 256);
        6: t = (v % 256) <= (c % 256);
        7: t = (v % 256) > (c % 256);
        8: t = (v % 256) >= (c % 256);
        default: t = 0;
      endcase
      if (op == 9)       pc = (ta + v % 16) % 4096;
      else if (op == 10) pc = (ta + v % 256) % 4096;
      else               pc = t ? ta : fa;
    end
  endtask

  task automatic runProg(string tag, int sa, logic [255:0] hdr, bit poke);
    logic [31:0] eRec;
    bit eForced;
    int n;
    refRun(sa, hdr, eRec, eForced);
    n = pcQ.size();
    @(negedge clk);
    startValid = 1; startAddr = 12'(sa); header = hdr;
    for (int k = 0; k <= 4*n; k++) begin
      @(negedge clk);
      startValid = poke && (k == 1);
      if (poke) begin startAddr = 12'hFFF; header = ~hdr; end
      check(tag, "busy", 32'(busy), 32'(k < 4*n));
      check(tag, "recValid", 32'(recValid), 32'(k == 4*n));
      check(tag, "memRe", 32'(memRe), 32'((k % 4 == 0) && (k < 4*n)));
      if ((k % 4 == 0) && (k < 4*n)) check(tag, "memAddr", 32'(memAddr), 32'(pcQ[k/4]));
      if (k == 4*n) begin
        check(tag, "record", record, eRec);
        check(tag, "recForced", 32'(recForced), 32'(eForced));
      end
    end
    startValid = 0;
  endtask

  task automatic single(string tag, int op, int rs, int mask, int cst, int val);
    mem[16'h010] = mk(op, rs, mask, cst, 12'h200, 12'h100);
    runProg(tag, 12'h010, hdrWith(rs, val), 0);
  endtask

  initial begin
    mem[12'h100] = exe(32'h0000_1111);
    mem[12'h200] = exe(32'h0000_2222);
    mem[12'h020] = mk(3, 0, 16'hFFFF, 5, 12'h200, 12'h021);
    mem[12'h021] = mk(0, 1, 16'hFFFF, 7, 12'h200, 12'h022);
    mem[12'h022] = exe(32'h3333_0000);
    mem[12'h300] = mk(9, 3, 16'h00FF, 0, 0, 12'h400);
    mem[12'h310] = mk(10, 4, 16'hFFFF, 0, 0, 12'h500);
    for (int i = 0; i < 16; i++)  mem[12'h400 + i] = exe(32'h4000_0000 + 32'(i));
    for (int i = 0; i < 256; i++) mem[12'h500 + i] = exe(32'h5000_0000 + 32'(i));
    mem[12'h700] = mk(0, 0, 0, 0, 12'h700, 12'h700);

    repeat (3) @(negedge clk);
    check("R9", "busy", 32'(busy), 0);
    check("R9", "memRe", 32'(memRe), 0);
    check("R9", "recValid", 32'(recValid), 0);
    rstN = 1;
    @(negedge clk);

    single("R3", 0, 2, 16'hFFFF, 16'h1234, 16'h1234);
    single("R3", 0, 2, 16'hFFFF, 16'h1234, 16'h1235);
    single("R3", 0, 2, 16'h00FF, 16'h0034, 16'h1234);
    single("R3", 0, 15, 16'hFFFF, 16'hBEEF, 16'hBEEF);
    single("R3", 1, 5, 16'hFFFF, 16'h0100, 16'h00FF);
    single("R3", 1, 5, 16'hFFFF, 16'h0100, 16'h0100);
    single("R3", 2, 5, 16'hFFFF, 16'h0100, 16'h0100);
    single("R3", 3, 5, 16'hFFFF, 16'h0100, 16'h0100);
    single("R3", 3, 5, 16'hFFFF, 16'h0100, 16'h0101);
    single("R3", 4, 5, 16'hFFFF, 16'h0100, 16'h0100);
    single("R4", 5, 7, 16'hFFFF, 16'h0010, 16'hFF0F);
    single("R4", 6, 7, 16'hFFFF, 16'h0010, 16'h0110);
    single("R4", 7, 7, 16'hFFFF, 16'hFF10, 16'h0011);
    single("R4", 8, 7, 16'hFFFF, 16'h0010, 16'hFF09);
    single("R10", 13, 1, 16'hFFFF, 16'h0000, 16'h0000);
    single("R10", 15, 1, 0, 0, 0);

    begin
      logic [255:0] h = hdrWith(0, 9);
      h[31:16] = 16'd7;
      runProg("R5", 12'h020, h, 0);
      runProg("R1", 12'h020, h, 1);
      h[31:16] = 16'd8;
      runProg("R5", 12'h020, h, 0);
    end
    runProg("R6", 12'h300, hdrWith(3, 16'hF0A7), 0);
    runProg("R6", 12'h310, hdrWith(4, 16'h12C3), 0);
    mem[12'h320] = mk(10, 4, 16'hFFFF, 0, 0, 12'hFF0);
    mem[12'h010] = exe(32'hC0DE_0010);
    runProg("R6", 12'h320, hdrWith(4, 16'h0020), 0);
    runProg("R7", 12'h100, hdrWith(0, 0), 0);
    runProg("R8", 12'h700, hdrWith(0, 0), 0);
    runProg("R7", 12'h200, hdrWith(0, 0), 0);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule